// File: doc/BRIEF.md
# Open Bank Tracker with Least-Recently-Used Replacement

This block records which DRAM bank and row pairs a memory controller currently holds open, within a small shared pool of open-bank slots. A scheduler asks it, for an incoming bank and row, whether the row is already open (hit), whether the bank is open on another row (conflict), or whether the bank is closed (miss). When a transaction is scheduled that should leave its row open, either because it spans more than one burst or because it carries an explicit keep-open hint, the scheduler asks the tracker to allocate a slot for it.

Slots are handed out dynamically rather than tied to banks. A request for a bank that is already open reuses that bank's slot. Otherwise the lowest free slot is used. When the pool is full, the least-recently-used slot is reclaimed. Whenever a slot's old row must be closed, the tracker raises a one-cycle precharge request that names the bank and the slot, and then installs the new entry. Lookup hits and installs both make the touched slot the most recent. A single-burst transaction without the keep-open hint takes no slot at all.

Allocation runs as a three-state machine. `ST_IDLE` accepts a request and picks the target slot. The path `ST_IDLE -> ST_PRECH` is taken when a granted request has to close a row, either by eviction or by a same-bank row conflict. `ST_PRECH -> ST_INSTALL` always follows, after the closed slot has been invalidated. `ST_IDLE -> ST_INSTALL` is taken directly for ungranted requests, for requests that go to a free slot, and for requests that hit an already open row. `ST_INSTALL -> ST_IDLE` writes the entry, promotes it, and reports completion.

Top module: `open_bank_tracker`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) marks every slot invalid, so every lookup misses. It sets the recency ranks to slot-index order, with slot 0 the most recent and slot NUM_SLOTS-1 the least recent, and returns the machine to idle with alloc_ready high.
- R2: With lkp_valid high, lkp_hit is 1 in the same cycle when a valid slot holds both lkp_bank and lkp_row. In that case lkp_conflict is 0 and lkp_slot gives that slot's index.
- R3: With lkp_valid high, lkp_conflict is 1 when a valid slot holds lkp_bank with a different row. In that case lkp_hit is 0 and lkp_slot gives that slot's index. When no slot matches, or when lkp_valid is low, both flags are 0 and lkp_slot is 0.
- R4: An accepted allocation with alloc_keep=0 and alloc_multi=0 completes with alloc_granted=0 and alloc_slot=0. It raises no precharge and changes no slot.
- R5: An accepted allocation with alloc_keep=1 or alloc_multi=1 completes with alloc_granted=1 and the chosen slot index. From the next cycle, a lookup of that bank and row hits that slot.
- R6: A granted request whose bank is not open takes the lowest-indexed invalid slot, with no precharge.
- R7: If every slot is valid and the bank is not open, the slot of rank NUM_SLOTS-1 (least recent) is evicted. pre_valid is high for exactly one cycle, carrying that slot's old bank on pre_bank and its index on pre_slot. alloc_done follows in the next cycle.
- R8: A granted request for a bank that is open on a different row reuses that bank's slot, raising the precharge pulse for it. No two valid slots ever hold the same bank.
- R9: A granted request for a bank and row that are already open completes on the same slot with no precharge.
- R10: A lookup hit, or a granted install, makes that slot the most recent. Every slot that was more recent than it moves down by one rank. An install that completes in the same cycle as a lookup hit takes precedence, and the lookup's promotion is dropped. Conflicts and misses leave the ranks unchanged.
- R11: alloc_ready is high only in idle. A request is accepted when alloc_valid and alloc_ready are both high. alloc_done pulses 1 cycle after acceptance without precharge, or 2 cycles after acceptance with precharge. alloc_valid is ignored while alloc_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lkp_valid | input | 1 | Lookup query present |
| lkp_bank | input | BANK_W | Bank to look up |
| lkp_row | input | ROW_W | Row to look up |
| lkp_hit | output | 1 | Bank open on the same row |
| lkp_conflict | output | 1 | Bank open on another row |
| lkp_slot | output | SLOT_W | Slot holding the bank, else 0 |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | Tracker idle, request accepted |
| alloc_bank | input | BANK_W | Bank of the transaction |
| alloc_row | input | ROW_W | Row of the transaction |
| alloc_keep | input | 1 | Keep-open hint |
| alloc_multi | input | 1 | Transaction spans several bursts |
| alloc_done | output | 1 | One-cycle completion pulse |
| alloc_granted | output | 1 | A slot was assigned |
| alloc_slot | output | SLOT_W | Assigned slot, 0 when not granted |
| pre_valid | output | 1 | One-cycle precharge request |
| pre_bank | output | BANK_W | Bank to precharge |
| pre_slot | output | SLOT_W | Slot being closed |

## Verification
The bench builds the tracker with NUM_SLOTS=4, BANK_W=3 and ROW_W=4, so there are eight banks competing for four slots. A handful of allocations is then enough to fill the pool and force least-recently-used evictions, and the four-bit row field makes same-bank row conflicts frequent under random traffic. With so few slots, a single lookup hit visibly moves the eviction victim, which brings the recency ordering and the install-over-lookup precedence within reach of short directed sequences as well as a long random run.

// File: rtl/obt_pkg.sv
package obt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PRECH   = 2'd1,
        ST_INSTALL = 2'd2
    } obt_state_e;

endpackage

// File: rtl/obt_prienc.sv
module obt_prienc #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] vec,
    output logic         found,
    output logic [W-1:0] idx
);

    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = W'(i);
            end
        end
    end

endmodule

// File: rtl/obt_slot_table.sv
module obt_slot_table #(
    parameter int N  = 8,
    parameter int BW = 4,
    parameter int RW = 14,
    parameter int SW = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [BW-1:0]        qa_bank,
    input  logic [RW-1:0]        qa_row,
    output logic [N-1:0]         qa_bmatch,
    output logic [N-1:0]         qa_rmatch,
    input  logic [BW-1:0]        qb_bank,
    input  logic [RW-1:0]        qb_row,
    output logic [N-1:0]         qb_bmatch,
    output logic [N-1:0]         qb_rmatch,
    input  logic                 wr_en,
    input  logic [SW-1:0]        wr_slot,
    input  logic [BW-1:0]        wr_bank,
    input  logic [RW-1:0]        wr_row,
    input  logic                 clr_en,
    input  logic [SW-1:0]        clr_slot,
    output logic [N-1:0]         valid_o,
    output logic [N-1:0][BW-1:0] bank_o
);

    logic [N-1:0][RW-1:0] row_q;

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_o[g] <= 1'b0;
                bank_o[g]  <= '0;
                row_q[g]   <= '0;
            end else if (wr_en && wr_slot == SW'(g)) begin
                valid_o[g] <= 1'b1;
                bank_o[g]  <= wr_bank;
                row_q[g]   <= wr_row;
            end else if (clr_en && clr_slot == SW'(g)) begin
                valid_o[g] <= 1'b0;
            end
        end

        assign qa_bmatch[g] = valid_o[g] && (bank_o[g] == qa_bank);
        assign qa_rmatch[g] = (row_q[g] == qa_row);
        assign qb_bmatch[g] = valid_o[g] && (bank_o[g] == qb_bank);
        assign qb_rmatch[g] = (row_q[g] == qb_row);
    end

endmodule

// File: rtl/obt_lru_ranks.sv
module obt_lru_ranks #(
    parameter int N  = 8,
    parameter int SW = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         promote_en,
    input  logic [SW-1:0] promote_slot,
    output logic [N-1:0] oldest_vec
);

    logic [N-1:0][SW-1:0] age_q;
    logic [SW-1:0]        sel_age;

    assign sel_age = age_q[promote_slot];

    for (genvar g = 0; g < N; g++) begin : g_rank
        always_ff @(posedge clk) begin
            if (rst) begin
                age_q[g] <= SW'(g);
            end else if (promote_en) begin
                if (promote_slot == SW'(g)) begin
                    age_q[g] <= '0;
                end else if (age_q[g] < sel_age) begin
                    age_q[g] <= age_q[g] + 1'b1;
                end
            end
        end

        assign oldest_vec[g] = (age_q[g] == SW'(N - 1));
    end

endmodule

// File: rtl/obt_ctrl.sv
module obt_ctrl
    import obt_pkg::*;
#(
    parameter int N  = 8,
    parameter int BW = 4,
    parameter int RW = 14,
    parameter int SW = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [BW-1:0]        req_bank,
    input  logic [RW-1:0]        req_row,
    input  logic                 req_keep,
    input  logic                 req_multi,
    input  logic                 bank_open,
    input  logic [SW-1:0]        bank_slot,
    input  logic                 row_same,
    input  logic                 free_found,
    input  logic [SW-1:0]        free_slot,
    input  logic [SW-1:0]        victim_slot,
    input  logic [N-1:0][BW-1:0] slot_bank,
    output logic                 ready,
    output logic                 pre_pulse,
    output logic [BW-1:0]        pre_bank_o,
    output logic [SW-1:0]        pre_slot_o,
    output logic                 done,
    output logic                 granted,
    output logic [SW-1:0]        done_slot,
    output logic                 wr_en,
    output logic [SW-1:0]        wr_slot,
    output logic [BW-1:0]        wr_bank,
    output logic [RW-1:0]        wr_row,
    output logic                 clr_en,
    output logic [SW-1:0]        clr_slot
);

    obt_state_e    state_q, state_d;
    logic [SW-1:0] tgt_q, tgt_d;
    logic          grant_q, grant_d;
    logic          need_pre_d;
    logic [BW-1:0] bank_q;
    logic [RW-1:0] row_q;
    logic [BW-1:0] old_bank_q;
    logic          accept;

    assign accept = (state_q == ST_IDLE) && req_valid;

    // target selection for an incoming request
    always_comb begin
        grant_d    = req_keep || req_multi;
        tgt_d      = '0;
        need_pre_d = 1'b0;
        if (grant_d) begin
            if (bank_open) begin
                tgt_d      = bank_slot;
                need_pre_d = !row_same;
            end else if (free_found) begin
                tgt_d      = free_slot;
            end else begin
                tgt_d      = victim_slot;
                need_pre_d = 1'b1;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = need_pre_d ? ST_PRECH : ST_INSTALL;
                end
            end
            ST_PRECH:   state_d = ST_INSTALL;
            ST_INSTALL: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request capture
    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q      <= '0;
            grant_q    <= 1'b0;
            bank_q     <= '0;
            row_q      <= '0;
            old_bank_q <= '0;
        end else if (accept) begin
            tgt_q      <= tgt_d;
            grant_q    <= grant_d;
            bank_q     <= req_bank;
            row_q      <= req_row;
            old_bank_q <= slot_bank[tgt_d];
        end
    end

    // outputs
    always_comb begin
        ready      = 1'b0;
        pre_pulse  = 1'b0;
        pre_bank_o = '0;
        pre_slot_o = '0;
        done       = 1'b0;
        granted    = 1'b0;
        done_slot  = '0;
        wr_en      = 1'b0;
        clr_en     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready = 1'b1;
            end
            ST_PRECH: begin
                pre_pulse  = 1'b1;
                pre_bank_o = old_bank_q;
                pre_slot_o = tgt_q;
                clr_en     = 1'b1;
            end
            ST_INSTALL: begin
                done      = 1'b1;
                granted   = grant_q;
                done_slot = tgt_q;
                wr_en     = grant_q;
            end
            default: begin
                ready = 1'b0;
            end
        endcase
    end

    assign wr_slot  = tgt_q;
    assign wr_bank  = bank_q;
    assign wr_row   = row_q;
    assign clr_slot = tgt_q;

endmodule

// File: rtl/open_bank_tracker.sv
module open_bank_tracker #(
    parameter  int NUM_SLOTS = 8,
    parameter  int BANK_W    = 4,
    parameter  int ROW_W     = 14,
    localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lkp_valid,
    input  logic [BANK_W-1:0] lkp_bank,
    input  logic [ROW_W-1:0]  lkp_row,
    output logic              lkp_hit,
    output logic              lkp_conflict,
    output logic [SLOT_W-1:0] lkp_slot,
    input  logic              alloc_valid,
    output logic              alloc_ready,
    input  logic [BANK_W-1:0] alloc_bank,
    input  logic [ROW_W-1:0]  alloc_row,
    input  logic              alloc_keep,
    input  logic              alloc_multi,
    output logic              alloc_done,
    output logic              alloc_granted,
    output logic [SLOT_W-1:0] alloc_slot,
    output logic              pre_valid,
    output logic [BANK_W-1:0] pre_bank,
    output logic [SLOT_W-1:0] pre_slot
);

    logic [NUM_SLOTS-1:0]             lkp_bmatch, lkp_rmatch;
    logic [NUM_SLOTS-1:0]             al_bmatch, al_rmatch;
    logic [NUM_SLOTS-1:0]             slot_valid;
    logic [NUM_SLOTS-1:0][BANK_W-1:0] slot_bank;
    logic [NUM_SLOTS-1:0]             oldest_vec;
    logic                             lkp_found, al_found, free_found, victim_found;
    logic [SLOT_W-1:0]                lkp_idx, al_idx, free_idx, victim_idx;
    logic                             wr_en, clr_en;
    logic [SLOT_W-1:0]                wr_slot, clr_slot;
    logic [BANK_W-1:0]                wr_bank;
    logic [ROW_W-1:0]                 wr_row;
    logic                             promote_en;
    logic [SLOT_W-1:0]                promote_slot;

    obt_slot_table #(
        .N(NUM_SLOTS), .BW(BANK_W), .RW(ROW_W), .SW(SLOT_W)
    ) u_table (
        .clk(clk), .rst(rst),
        .qa_bank(lkp_bank), .qa_row(lkp_row),
        .qa_bmatch(lkp_bmatch), .qa_rmatch(lkp_rmatch),
        .qb_bank(alloc_bank), .qb_row(alloc_row),
        .qb_bmatch(al_bmatch), .qb_rmatch(al_rmatch),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_bank(wr_bank), .wr_row(wr_row),
        .clr_en(clr_en), .clr_slot(clr_slot),
        .valid_o(slot_valid), .bank_o(slot_bank)
    );

    obt_prienc #(.N(NUM_SLOTS), .W(SLOT_W)) u_enc_lkp (
        .vec(lkp_bmatch), .found(lkp_found), .idx(lkp_idx)
    );

    obt_prienc #(.N(NUM_SLOTS), .W(SLOT_W)) u_enc_alloc (
        .vec(al_bmatch), .found(al_found), .idx(al_idx)
    );

    obt_prienc #(.N(NUM_SLOTS), .W(SLOT_W)) u_enc_free (
        .vec(~slot_valid), .found(free_found), .idx(free_idx)
    );

    obt_prienc #(.N(NUM_SLOTS), .W(SLOT_W)) u_enc_victim (
        .vec(oldest_vec), .found(victim_found), .idx(victim_idx)
    );

    obt_lru_ranks #(.N(NUM_SLOTS), .SW(SLOT_W)) u_ranks (
        .clk(clk), .rst(rst),
        .promote_en(promote_en), .promote_slot(promote_slot),
        .oldest_vec(oldest_vec)
    );

    obt_ctrl #(
        .N(NUM_SLOTS), .BW(BANK_W), .RW(ROW_W), .SW(SLOT_W)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(alloc_valid), .req_bank(alloc_bank), .req_row(alloc_row),
        .req_keep(alloc_keep), .req_multi(alloc_multi),
        .bank_open(al_found), .bank_slot(al_idx),
        .row_same(|(al_bmatch & al_rmatch)),
        .free_found(free_found), .free_slot(free_idx),
        .victim_slot(victim_idx), .slot_bank(slot_bank),
        .ready(alloc_ready),
        .pre_pulse(pre_valid), .pre_bank_o(pre_bank), .pre_slot_o(pre_slot),
        .done(alloc_done), .granted(alloc_granted), .done_slot(alloc_slot),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_bank(wr_bank), .wr_row(wr_row),
        .clr_en(clr_en), .clr_slot(clr_slot)
    );

    // lookup results
    always_comb begin
        lkp_hit      = lkp_valid && |(lkp_bmatch & lkp_rmatch);
        lkp_conflict = lkp_valid && lkp_found && !(|(lkp_bmatch & lkp_rmatch));
        lkp_slot     = (lkp_valid && lkp_found) ? lkp_idx : '0;
    end

    // recency update: install wins over a lookup hit
    always_comb begin
        promote_en   = wr_en || lkp_hit;
        promote_slot = wr_en ? wr_slot : lkp_idx;
    end

endmodule

// File: rtl/obt_checker.sv
module obt_checker #(
    parameter int N  = 8,
    parameter int BW = 4,
    parameter int SW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          lkp_hit,
    input logic          lkp_conflict,
    input logic          alloc_valid,
    input logic          alloc_ready,
    input logic          alloc_done,
    input logic          alloc_granted,
    input logic          pre_valid,
    input logic [N-1:0]  bmatch,
    input logic [N-1:0]  oldest
);

    // R2 / R3: hit and conflict never together
    a_r3_hit_conflict_excl: assert property (@(posedge clk) disable iff (rst)
        !(lkp_hit && lkp_conflict));

    // R7: precharge pulse lasts one cycle
    a_r7_pre_single: assert property (@(posedge clk) disable iff (rst)
        pre_valid |=> !pre_valid);

    // R7: completion follows the precharge pulse
    a_r7_pre_then_done: assert property (@(posedge clk) disable iff (rst)
        pre_valid |=> alloc_done);

    // R11: acceptance drops ready next cycle
    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && alloc_ready) |=> !alloc_ready);

    // R11: done only outside idle
    a_r11_done_not_ready: assert property (@(posedge clk) disable iff (rst)
        alloc_done |-> !alloc_ready);

    // R4: ungranted completion is never preceded by a precharge
    a_r4_no_grant_no_pre: assert property (@(posedge clk) disable iff (rst)
        (alloc_done && !alloc_granted) |-> !$past(pre_valid));

    // R8: a bank is open in at most one slot
    a_r8_bank_unique: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bmatch));

    // R10: exactly one slot holds the oldest rank
    a_r10_single_oldest: assert property (@(posedge clk) disable iff (rst)
        $countones(oldest) == 1);

endmodule

bind open_bank_tracker obt_checker #(
    .N(NUM_SLOTS), .BW(BANK_W), .SW(SLOT_W)
) u_obt_checker (
    .clk(clk), .rst(rst),
    .lkp_hit(lkp_hit), .lkp_conflict(lkp_conflict),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_done(alloc_done), .alloc_granted(alloc_granted),
    .pre_valid(pre_valid),
    .bmatch(lkp_bmatch), .oldest(oldest_vec)
);

// File: tb/tb_open_bank_tracker.sv
`timescale 1ns/1ps
module tb_open_bank_tracker;

    localparam int N  = 4;
    localparam int BW = 3;
    localparam int RW = 4;
    localparam int SW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lkp_valid = 1'b0;
    logic [BW-1:0] lkp_bank = '0;
    logic [RW-1:0] lkp_row = '0;
    logic lkp_hit, lkp_conflict;
    logic [SW-1:0] lkp_slot;
    logic alloc_valid = 1'b0;
    logic alloc_ready;
    logic [BW-1:0] alloc_bank = '0;
    logic [RW-1:0] alloc_row = '0;
    logic alloc_keep = 1'b0, alloc_multi = 1'b0;
    logic alloc_done, alloc_granted;
    logic [SW-1:0] alloc_slot;
    logic pre_valid;
    logic [BW-1:0] pre_bank;
    logic [SW-1:0] pre_slot;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    open_bank_tracker #(.NUM_SLOTS(N), .BANK_W(BW), .ROW_W(RW)) dut (
        .clk(clk), .rst(rst),
        .lkp_valid(lkp_valid), .lkp_bank(lkp_bank), .lkp_row(lkp_row),
        .lkp_hit(lkp_hit), .lkp_conflict(lkp_conflict), .lkp_slot(lkp_slot),
        .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
        .alloc_bank(alloc_bank), .alloc_row(alloc_row),
        .alloc_keep(alloc_keep), .alloc_multi(alloc_multi),
        .alloc_done(alloc_done), .alloc_granted(alloc_granted), .alloc_slot(alloc_slot),
        .pre_valid(pre_valid), .pre_bank(pre_bank), .pre_slot(pre_slot)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_state = 0;      // 0 idle, 1 closing, 2 installing
    int m_tgt = 0, m_gr = 0, m_bank = 0, m_row = 0, m_pbank = 0;
    int mv[N], mb[N], mr[N], ma[N];
    bit started = 0;

    function automatic int bank_at(input int bank);
        for (int i = 0; i < N; i++) if (mv[i] != 0 && mb[i] == bank) return i;
        return -1;
    endfunction

    task automatic m_promote(input int s);
        int old = ma[s];
        for (int i = 0; i < N; i++) if (ma[i] < old) ma[i]++;
        ma[s] = 0;
    endtask

    always @(negedge clk) begin
        int f, e_hit, e_conf, e_slot, f2, lk_hit_slot;
        if (started) begin
            f      = bank_at(int'(lkp_bank));
            e_hit  = (lkp_valid && f >= 0 && mr[f] == int'(lkp_row)) ? 1 : 0;
            e_conf = (lkp_valid && f >= 0 && mr[f] != int'(lkp_row)) ? 1 : 0;
            e_slot = (lkp_valid && f >= 0) ? f : 0;
            check(lkp_hit == e_hit, "R2 hit", lkp_hit, e_hit);
            check(lkp_conflict == e_conf, "R3 conflict", lkp_conflict, e_conf);
            check(int'(lkp_slot) == e_slot, "R3 slot", lkp_slot, e_slot);
            check(alloc_ready == (m_state == 0), "R11 ready", alloc_ready, m_state == 0);
            check(pre_valid == (m_state == 1), "R7 pre_valid", pre_valid, m_state == 1);
            check(int'(pre_bank) == ((m_state == 1) ? m_pbank : 0), "R7 pre_bank",
                  pre_bank, (m_state == 1) ? m_pbank : 0);
            check(int'(pre_slot) == ((m_state == 1) ? m_tgt : 0), "R8 pre_slot",
                  pre_slot, (m_state == 1) ? m_tgt : 0);
            check(alloc_done == (m_state == 2), "R11 done", alloc_done, m_state == 2);
            check(alloc_granted == (m_state == 2 && m_gr != 0), "R5 granted",
                  alloc_granted, m_state == 2 && m_gr != 0);
            check(int'(alloc_slot) == ((m_state == 2) ? m_tgt : 0), "R6 slot",
                  alloc_slot, (m_state == 2) ? m_tgt : 0);
        end
        if (rst) begin
            for (int i = 0; i < N; i++) begin mv[i] = 0; mb[i] = 0; mr[i] = 0; ma[i] = i; end
            m_state = 0; m_tgt = 0; m_gr = 0;
            started = 1;
        end else if (started) begin
            f = bank_at(int'(lkp_bank));
            lk_hit_slot = (lkp_valid && f >= 0 && mr[f] == int'(lkp_row)) ? f : -1;
            case (m_state)
                0: begin
                    if (alloc_valid) begin
                        m_gr = (alloc_keep || alloc_multi) ? 1 : 0;
                        m_bank = int'(alloc_bank); m_row = int'(alloc_row);
                        m_tgt = 0;
                        m_state = 2;
                        if (m_gr != 0) begin
                            f2 = bank_at(m_bank);
                            if (f2 >= 0) begin
                                m_tgt = f2;
                                if (mr[f2] != m_row) m_state = 1;
                            end else begin
                                m_tgt = -1;
                                for (int i = N - 1; i >= 0; i--) if (mv[i] == 0) m_tgt = i;
                                if (m_tgt < 0) begin
                                    for (int i = 0; i < N; i++) if (ma[i] == N - 1) m_tgt = i;
                                    m_state = 1;
                                end
                            end
                        end
                        m_pbank = mb[m_tgt];
                    end
                    if (lk_hit_slot >= 0) m_promote(lk_hit_slot);
                end
                1: begin
                    if (lk_hit_slot >= 0) m_promote(lk_hit_slot);
                    mv[m_tgt] = 0;
                    m_state = 2;
                end
                default: begin
                    if (m_gr != 0) begin
                        mv[m_tgt] = 1; mb[m_tgt] = m_bank; mr[m_tgt] = m_row;
                        m_promote(m_tgt);
                    end else if (lk_hit_slot >= 0) begin
                        m_promote(lk_hit_slot);
                    end
                    m_state = 0;
                end
            endcase
        end
    end

    // ---------------- directed helpers ----------------
    int seen_pre, seen_pbank, seen_done_slot, seen_gr, seen_lat;

    task automatic do_alloc(input int b, input int r, input bit k, input bit m);
        while (!alloc_ready) @(negedge clk);
        @(posedge clk); #1;
        alloc_valid = 1; alloc_bank = BW'(b); alloc_row = RW'(r);
        alloc_keep = k; alloc_multi = m;
        @(posedge clk); #1;
        alloc_valid = 0;
        seen_pre = 0; seen_pbank = -1; seen_done_slot = -1; seen_gr = -1; seen_lat = 0;
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            if (pre_valid) begin seen_pre++; seen_pbank = int'(pre_bank); end
            if (alloc_done && seen_lat == 0) begin
                seen_lat = i; seen_done_slot = int'(alloc_slot); seen_gr = int'(alloc_granted);
            end
        end
    endtask

    task automatic do_lookup(input int b, input int r, input int eh, input int ec,
                             input int es, input string req);
        @(posedge clk); #1;
        lkp_valid = 1; lkp_bank = BW'(b); lkp_row = RW'(r);
        @(negedge clk);
        check(lkp_hit == eh, req, lkp_hit, eh);
        check(lkp_conflict == ec, req, lkp_conflict, ec);
        check(int'(lkp_slot) == es, req, lkp_slot, es);
        @(posedge clk); #1;
        lkp_valid = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check(alloc_ready == 1, "R1 ready after reset", alloc_ready, 1);
        do_lookup(1, 2, 0, 0, 0, "R1 empty after reset");

        do_alloc(1, 2, 0, 0);
        check(seen_gr == 0 && seen_pre == 0, "R4 no grant", seen_gr, 0);
        do_lookup(1, 2, 0, 0, 0, "R4 no slot taken");

        do_alloc(1, 2, 1, 0);
        check(seen_done_slot == 0 && seen_lat == 1, "R6 first free slot, R11 latency",
              seen_done_slot, 0);
        do_lookup(1, 2, 1, 0, 0, "R5 hit after keep");
        do_alloc(2, 3, 0, 1);
        check(seen_done_slot == 1 && seen_gr == 1, "R5 multi-burst grant", seen_done_slot, 1);
        do_alloc(3, 1, 1, 0);
        do_alloc(4, 5, 1, 0);
        check(seen_done_slot == 3, "R6 fill order", seen_done_slot, 3);
        do_lookup(1, 2, 1, 0, 0, "R10 hit promotes slot 0");
        do_lookup(3, 9, 0, 1, 2, "R3 row conflict");

        do_alloc(5, 6, 1, 0);
        check(seen_pre == 1 && seen_pbank == 2, "R7 evict LRU bank", seen_pbank, 2);
        check(seen_done_slot == 1 && seen_lat == 2, "R7 victim slot after promote R10",
              seen_done_slot, 1);
        do_lookup(2, 3, 0, 0, 0, "R7 evicted bank closed");
        do_lookup(5, 6, 1, 0, 1, "R5 new entry");

        do_alloc(4, 7, 1, 0);
        check(seen_pre == 1 && seen_pbank == 4 && seen_done_slot == 3,
              "R8 same-bank row reuse", seen_done_slot, 3);
        do_lookup(4, 7, 1, 0, 3, "R8 new row open");

        do_alloc(1, 2, 0, 1);
        check(seen_pre == 0 && seen_done_slot == 0 && seen_lat == 1, "R9 already open",
              seen_pre, 0);
        do_lookup(5, 6, 1, 0, 1, "R10 touch slot 1");
        do_alloc(6, 1, 1, 0);
        check(seen_pre == 1 && seen_pbank == 3 && seen_done_slot == 2, "R10 victim order",
              seen_pbank, 3);

        // random traffic, including requests while busy (R11)
        for (int n = 0; n < 3000; n++) begin
            @(posedge clk); #1;
            lkp_valid   = ($urandom % 2) == 0;
            lkp_bank    = BW'($urandom);
            lkp_row     = RW'($urandom % 3);
            alloc_valid = ($urandom % 3) == 0;
            alloc_bank  = BW'($urandom);
            alloc_row   = RW'($urandom % 3);
            alloc_keep  = ($urandom % 2) == 0;
            alloc_multi = ($urandom % 3) == 0;
            if (n == 1500) rst = 1;
            if (n == 1502) rst = 0;
        end
        @(posedge clk); #1;
        lkp_valid = 0; alloc_valid = 0;
        repeat (4) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule